// File: doc/BRIEF.md
# Multi-Channel DMA Bandwidth Arbiter

This block shares one transfer interface among four DMA channels. Each channel presents a request line, a done flag and a 3-bit bandwidth code. The code sets how many cache lines the channel may move per grant: one, two, four, eight or sixteen. The interface sends a one-cycle pulse each time it completes a cache line. The arbiter counts these pulses for the channel that holds the grant. When the quota is used up and another channel is waiting, the grant passes to that channel.

The quota applies only under contention. A channel that is the only eligible requester keeps the interface for as long as it asks. If another channel starts requesting later, the holder's count already includes every line it has moved, so the holder gives way at its next line pulse once the quota is reached. A holder that drops its request or raises done gives up the grant at once. Hand-over follows round-robin order, starting with the channel after the one that released. A channel with a larger code therefore gets a larger share of the bandwidth.

No data passes through the block, so it has no valid/ready stream. All of its pins are plain level or pulse controls. The grant is held as a register, so a change on the inputs shows on the grant outputs at the next rising clock edge.

Top module: `dma_bw_arbiter`

## Requirements
- R1: Bandwidth codes 0, 1, 2, 3 and 4 (binary 000 to 100) give a per-grant quota of 1, 2, 4, 8 and 16 cache lines. Under contention, the grant moves away on the edge that takes the quota-th line pulse.
- R2: Bandwidth codes 5, 6 and 7 give a quota of 16 lines.
- R3: `grant` has at most one bit set, and `grant_vld` is high exactly when a bit is set.
- R4: Synchronous active-high reset clears the grant. The first grant after reset goes to the lowest-numbered eligible channel. A channel is eligible when its `req` is high and its `done` is low.
- R5: When another channel is eligible, the holder releases on the clock edge that takes a line pulse bringing its count to the quota. Lines counted while it was the only requester are included in that count.
- R6: While no other channel is eligible, the holder keeps the grant through any number of line pulses, past its quota.
- R7: A holder whose `req` falls or whose `done` rises loses the grant on the next edge, whatever its count.
- R8: On release, the next grant goes to the first eligible channel in rotating order, starting at the channel after the releaser.
- R9: The line count restarts at zero on every new grant. A channel granted again receives its full quota.
- R10: With no eligible channel, `grant` is zero, and only an eligible channel is ever granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 4 | Per-channel request level |
| done | input | 4 | Per-channel done level; masks the request |
| bw_code | input | 12 | Per-channel 3-bit quota code, channel i at bits [3i+2:3i] |
| line_done | input | 1 | One-cycle pulse per completed cache line on the shared interface |
| grant | output | 4 | One-hot grant to the holding channel |
| grant_vld | output | 1 | High while some channel holds the grant |

## Verification
The assertions assume that `line_done` refers to the current holder. They also assume that the inputs are stable around the clock edge and are known once reset is released. The bench drives every input half a period after the active edge. It raises `line_done` for exactly one cycle, and only while a grant is held. Requests and codes stay fixed for the whole of a quota window unless a scenario changes them on purpose.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;
  localparam int CODE_W  = 3;
  localparam int MAX_LOG = 4;
  localparam int CNT_W   = MAX_LOG + 1;

  function automatic logic [CNT_W-1:0] code_to_lines(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] one;
    one = {{(CNT_W-1){1'b0}}, 1'b1};
    if (int'(code) > MAX_LOG) return one << MAX_LOG;
    return one << code;
  endfunction
endpackage

// File: rtl/dma_quota_decode.sv
module dma_quota_decode
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic [NCH*CODE_W-1:0] codes,
  output logic [NCH*CNT_W-1:0]  quotas
);
  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign quotas[i*CNT_W +: CNT_W] = code_to_lines(codes[i*CODE_W +: CODE_W]);
  end
endmodule

// File: rtl/dma_rr_picker.sv
module dma_rr_picker #(
  parameter int NCH   = 4,
  parameter int IDX_W = $clog2(NCH)
) (
  input  logic [NCH-1:0]   elig,
  input  logic [IDX_W-1:0] start,
  output logic [NCH-1:0]   pick,
  output logic             pick_vld
);
  always_comb begin
    pick     = '0;
    pick_vld = 1'b0;
    for (int k = 1; k <= NCH; k++) begin
      int idx;
      idx = (int'(start) + k) % NCH;
      if (!pick_vld && elig[idx]) begin
        pick[idx] = 1'b1;
        pick_vld  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma_line_counter.sv
module dma_line_counter
  import dma_arb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             inc,
  output logic [CNT_W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst || clear) count <= '0;
    else if (inc && count != {CNT_W{1'b1}}) count <= count + 1'b1;
  end

  p_cnt_clear_r9: assert property (@(posedge clk) disable iff (rst)
    clear |=> count == '0);
endmodule

// File: rtl/dma_bw_arbiter.sv
module dma_bw_arbiter
  import dma_arb_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [NCH-1:0]        req,
  input  logic [NCH-1:0]        done,
  input  logic [NCH*CODE_W-1:0] bw_code,
  input  logic                  line_done,
  output logic [NCH-1:0]        grant,
  output logic                  grant_vld
);
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(NCH - 1);

  logic [NCH-1:0]       grant_q, elig, others, pick, nxt_grant;
  logic                 pick_vld, contended, hold_ok, quota_hit, release_now;
  logic                 need_pick, new_grant, held;
  logic [IDX_W-1:0]     cur_idx, last_q, start;
  logic [NCH*CNT_W-1:0] quotas;
  logic [CNT_W-1:0]     quota_sel, cnt_q;

  assign elig      = req & ~done;
  assign held      = |grant_q;
  assign others    = elig & ~grant_q;
  assign contended = |others;
  assign hold_ok   = |(grant_q & elig);

  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < NCH; i++)
      if (grant_q[i]) cur_idx = IDX_W'(i);
  end

  dma_quota_decode #(.NCH(NCH)) u_dec (.codes(bw_code), .quotas(quotas));

  assign quota_sel   = quotas[cur_idx*CNT_W +: CNT_W];
  assign quota_hit   = held && line_done && contended && (cnt_q >= quota_sel - 1'b1);
  assign release_now = held && (!hold_ok || quota_hit);
  assign need_pick   = !held || release_now;
  assign start       = held ? cur_idx : last_q;

  dma_rr_picker #(.NCH(NCH), .IDX_W(IDX_W)) u_pick (
    .elig(elig), .start(start), .pick(pick), .pick_vld(pick_vld));

  assign nxt_grant = need_pick ? pick : grant_q;
  assign new_grant = need_pick && pick_vld;

  always_ff @(posedge clk) begin
    if (rst) begin
      grant_q <= '0;
      last_q  <= LAST_INIT;
    end else begin
      grant_q <= nxt_grant;
      if (held) last_q <= cur_idx;
    end
  end

  dma_line_counter u_cnt (
    .clk(clk), .rst(rst), .clear(new_grant),
    .inc(line_done && held), .count(cnt_q));

  assign grant     = grant_q;
  assign grant_vld = held;

  p_onehot_r3: assert property (@(posedge clk) disable iff (rst) $onehot0(grant));
  p_vld_r3: assert property (@(posedge clk) disable iff (rst) grant_vld == (grant != '0));
  p_quota_release_r5: assert property (@(posedge clk) disable iff (rst)
    quota_hit |=> grant != $past(grant));
  p_pick_elig_r10: assert property (@(posedge clk) disable iff (rst)
    pick_vld |-> (pick & ~elig) == '0);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    p_quota_pow2_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot(quotas[i*CNT_W +: CNT_W]));
    p_drop_release_r7: assert property (@(posedge clk) disable iff (rst)
      (grant_q[i] && !elig[i]) |=> !grant_q[i]);
    p_hold_alone_r6: assert property (@(posedge clk) disable iff (rst)
      (grant_q[i] && elig[i] && !contended) |=> grant_q[i]);
  end
endmodule

// File: tb/dma_bw_arbiter_bench.sv
module dma_bw_arbiter_bench;
  localparam int PERIOD = 10;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst;
  logic [NCH-1:0] req, done, grant;
  logic [3*NCH-1:0] bw_code;
  logic line_done, grant_vld;
  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #(PERIOD/2) clk = ~clk;

  dma_bw_arbiter #(.NCH(NCH)) u_dma_bw_arbiter (
    .clk(clk), .rst(rst), .req(req), .done(done), .bw_code(bw_code),
    .line_done(line_done), .grant(grant), .grant_vld(grant_vld));

  // code -> expected quota
  localparam int NVEC = 8;
  localparam logic [2:0] VCODE [NVEC] = '{3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7};
  localparam int VLINES [NVEC] = '{1, 2, 4, 8, 16, 16, 16, 16};

  task automatic tick();
    @(posedge clk);
    #(PERIOD/2);
  endtask

  task automatic check(input string tag, input logic [NCH-1:0] exp);
    n_chk++;
    if (grant !== exp || grant_vld !== (exp != '0)) begin
      n_bad++;
      $display("FAIL %s: grant=%b vld=%b expected grant=%b vld=%b",
               tag, grant, grant_vld, exp, exp != '0);
    end
  endtask

  task automatic pulse();
    line_done = 1'b1;
    tick();
    line_done = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1; req = '0; done = '0; line_done = 1'b0; bw_code = '0;
    tick(); tick();
    rst = 1'b0;
  endtask

  initial begin
    #(PERIOD * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(PERIOD/4);
    do_reset();
    check("R3 R4 reset idle", 4'b0000);

    // R1/R2/R5: quota per code under contention
    for (int v = 0; v < NVEC; v++) begin
      do_reset();
      bw_code = {3'd0, 3'd0, 3'd0, VCODE[v]};
      req = 4'b0011;
      tick();
      check("R4 first grant lowest", 4'b0001);
      for (int p = 1; p < VLINES[v]; p++) pulse();
      check(v < 5 ? "R1 holds before quota" : "R2 holds before quota", 4'b0001);
      pulse();
      check(v < 5 ? "R1 release at quota" : "R2 release at quota", 4'b0010);
    end

    // R4: lowest eligible after reset
    do_reset();
    req = 4'b1100;
    tick();
    check("R4 lowest of 1100", 4'b0100);

    // R6: alone, kept past quota
    req = 4'b0100;
    pulse(); pulse(); pulse();
    check("R6 alone past quota", 4'b0100);
    // R5: contender arrives after quota already spent
    req = 4'b0110;
    tick();
    check("R5 no pulse no release", 4'b0100);
    pulse();
    check("R5 release on next line", 4'b0010);

    // R8: rotation
    do_reset();
    req = 4'b1111;
    tick();
    check("R8 start ch0", 4'b0001);
    pulse(); check("R8 to ch1", 4'b0010);
    pulse(); check("R8 to ch2", 4'b0100);
    pulse(); check("R8 to ch3", 4'b1000);
    pulse(); check("R8 wrap ch0", 4'b0001);
    req = 4'b1011;
    pulse(); check("R8 ch1", 4'b0010);
    pulse(); check("R8 skip ch2", 4'b1000);

    // R7: drop and done
    do_reset();
    bw_code = {3'd0, 3'd0, 3'd3, 3'd3};
    req = 4'b0011;
    tick();
    pulse();
    req = 4'b0010;
    tick();
    check("R7 drop releases", 4'b0010);
    req = 4'b0011;
    pulse();
    done = 4'b0010;
    tick();
    check("R7 done releases", 4'b0001);
    done = 4'b0000;

    // R9: count restarts on regrant
    do_reset();
    bw_code = {3'd0, 3'd0, 3'd1, 3'd1};
    req = 4'b0011;
    tick();
    pulse(); pulse();
    check("R9 ch1 after 2", 4'b0010);
    pulse(); pulse();
    check("R9 ch0 again", 4'b0001);
    pulse();
    check("R9 full quota again", 4'b0001);
    pulse();
    check("R9 release after 2", 4'b0010);

    // R10: idle when nothing eligible
    req = 4'b0000;
    tick();
    check("R10 idle", 4'b0000);
    done = 4'b0100; req = 4'b0100;
    tick();
    check("R10 done masks request", 4'b0000);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule